// File: doc/BRIEF.md
# Hybrid Coarse/Fine Funnel Shifter

This block pulls a 32-bit window out of a 64-bit operand. The operand is built from two 32-bit words, `hi_in` above `lo_in`. A 5-bit count sets how far the operand moves to the left, and the upper half of the moved value is returned. The block covers every rotate and shift that an execution unit builds by choosing the two operand words. A rotate uses the same word in both halves. A logical left shift puts zero in the low half. Flags and operand preparation are left to the logic around the block.

The datapath has two stages. The upper count bits go to a one-hot decoder. Its select lines pick one of eight 36-bit slices, spaced four bit positions apart. The two lowest count bits then drive two binary levels, which move that slice by 0 to 3 more positions. The whole shift fits in one cycle. An output register is optional: with it, a result appears one cycle after its operands are accepted.

The data interface uses a valid/ready handshake. An item transfers on a rising clock edge when valid and ready are both high. A result held in the output register waits until the consumer accepts it. While it waits, the output value and `out_valid` stay constant and `in_ready` is low. A new item can still be accepted in the same cycle that the held result leaves.

Top module: `funnel_shift_mt`

## Requirements
- R1: For every count c from 0 to 31, `result_out` equals bits 63..32 of ({hi_in, lo_in} << c).
- R2: A count of zero returns `hi_in` unchanged.
- R3: A count of 31 returns {hi_in[0], lo_in[31:1]}.
- R4: Exactly one of the eight coarse select lines is active at any time, and its index is count_in[4:2]. Counts that are multiples of four need only the coarse stage and match R1.
- R5: In the registered variant, `out_valid` is high in the cycle after an accepted input and carries that input's result.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result_out` keeps its value.
- R7: `in_ready` is high exactly when the output register is empty or its result is being taken in the same cycle. After reset it is high.
- R8: After reset, `out_valid` is low.
- R9: When `in_valid` is low, nothing is accepted. Once the held result has been taken, `out_valid` goes low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and count are valid |
| in_ready | output | 1 | The block can accept an item this cycle |
| hi_in | input | 32 | Upper operand word |
| lo_in | input | 32 | Lower operand word |
| count_in | input | 5 | Left shift amount, 0 to 31 |
| out_valid | output | 1 | `result_out` holds a result |
| out_ready | input | 1 | The consumer accepts the result |
| result_out | output | 32 | Selected 32-bit window |

## Verification
The bench builds the block with its default values: a width of 32, a coarse step of 4, and the registered output. At this size the full count range is small, so every count from 0 to 31 is applied under several data patterns. Together these reach all eight coarse select lines and all four fine offsets. Random back-pressure on `out_ready` produces stall and same-cycle drain-and-refill cases. Directed phases pin down the latency, the held output and `in_ready` going low.

// File: rtl/funnel_shift_mt_pkg.sv
package funnel_shift_mt_pkg;
  typedef enum logic {OUT_COMB = 1'b0, OUT_REGISTERED = 1'b1} out_mode_e;

  localparam int DEF_WIDTH = 32;
  localparam int DEF_STEP  = 4;
endpackage

// File: rtl/fsm_count_decode.sv
module fsm_count_decode #(
  parameter int N_SEL = 8,
  localparam int CW = $clog2(N_SEL)
) (
  input  logic [CW-1:0]    code,
  output logic [N_SEL-1:0] sel
);
  for (genvar k = 0; k < N_SEL; k++) begin : g_line
    assign sel[k] = (code == CW'(k));
  end
endmodule

// File: rtl/fsm_coarse_stage.sv
module fsm_coarse_stage #(
  parameter int WIDTH = 32,
  parameter int STEP  = 4,
  localparam int N_SEL = WIDTH / STEP,
  localparam int MID_W = WIDTH + STEP
) (
  input  logic [2*WIDTH-1:0] operand,
  input  logic [N_SEL-1:0]   sel,
  output logic [MID_W-1:0]   mid
);
  logic [MID_W-1:0] slice [N_SEL];

  for (genvar k = 0; k < N_SEL; k++) begin : g_slice
    assign slice[k] = operand[2*WIDTH-1-k*STEP -: MID_W];
  end

  always_comb begin
    mid = '0;
    for (int k = 0; k < N_SEL; k++) begin
      mid = mid | ({MID_W{sel[k]}} & slice[k]);
    end
  end
endmodule

// File: rtl/fsm_fine_stage.sv
module fsm_fine_stage #(
  parameter int WIDTH = 32,
  parameter int STEP  = 4,
  localparam int LVLS  = $clog2(STEP),
  localparam int MID_W = WIDTH + STEP
) (
  input  logic [MID_W-1:0] mid,
  input  logic [LVLS-1:0]  amt,
  output logic [WIDTH-1:0] res
);
  logic [MID_W-1:0] lvl [LVLS+1];

  assign lvl[0] = mid;
  for (genvar i = 0; i < LVLS; i++) begin : g_level
    assign lvl[i+1] = amt[i] ? (lvl[i] << (1 << i)) : lvl[i];
  end

  assign res = lvl[LVLS][MID_W-1 -: WIDTH];
endmodule

// File: rtl/fsm_out_stage.sv
module fsm_out_stage
  import funnel_shift_mt_pkg::*;
#(
  parameter int        WIDTH = 32,
  parameter out_mode_e MODE  = OUT_REGISTERED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] d,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] q
);
  if (MODE == OUT_REGISTERED) begin : g_reg
    logic             vld_q;
    logic [WIDTH-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign q         = dat_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) begin
        dat_q <= d;
      end
    end
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign q         = d;
  end
endmodule

// File: rtl/funnel_shift_mt.sv
module funnel_shift_mt
  import funnel_shift_mt_pkg::*;
#(
  parameter int        WIDTH    = DEF_WIDTH,
  parameter int        STEP     = DEF_STEP,
  parameter out_mode_e OUT_MODE = OUT_REGISTERED
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WIDTH-1:0]         hi_in,
  input  logic [WIDTH-1:0]         lo_in,
  input  logic [$clog2(WIDTH)-1:0] count_in,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [WIDTH-1:0]         result_out
);
  localparam int CNT_W  = $clog2(WIDTH);
  localparam int FINE_W = $clog2(STEP);
  localparam int N_SEL  = WIDTH / STEP;
  localparam int MID_W  = WIDTH + STEP;

  logic [N_SEL-1:0] coarse_sel;
  logic [MID_W-1:0] mid_word;
  logic [WIDTH-1:0] shifted;

  fsm_count_decode #(.N_SEL(N_SEL)) u_dec (
    .code (count_in[CNT_W-1:FINE_W]),
    .sel  (coarse_sel)
  );

  fsm_coarse_stage #(.WIDTH(WIDTH), .STEP(STEP)) u_coarse (
    .operand ({hi_in, lo_in}),
    .sel     (coarse_sel),
    .mid     (mid_word)
  );

  fsm_fine_stage #(.WIDTH(WIDTH), .STEP(STEP)) u_fine (
    .mid (mid_word),
    .amt (count_in[FINE_W-1:0]),
    .res (shifted)
  );

  fsm_out_stage #(.WIDTH(WIDTH), .MODE(OUT_MODE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (shifted),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (result_out)
  );
endmodule

// File: rtl/funnel_shift_mt_chk.sv
module funnel_shift_mt_chk
  import funnel_shift_mt_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter int        STEP     = 4,
  parameter out_mode_e OUT_MODE = OUT_REGISTERED,
  localparam int CNT_W  = $clog2(WIDTH),
  localparam int FINE_W = $clog2(STEP),
  localparam int N_SEL  = WIDTH / STEP
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [WIDTH-1:0]     hi_in,
  input logic [WIDTH-1:0]     lo_in,
  input logic [CNT_W-1:0]     count_in,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [WIDTH-1:0]     result_out,
  input logic [N_SEL-1:0]     coarse_sel
);
  logic [2*WIDTH-1:0] model_full;
  assign model_full = {hi_in, lo_in} << count_in;

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(coarse_sel) && coarse_sel[count_in[CNT_W-1:FINE_W]]);

  if (OUT_MODE == OUT_REGISTERED) begin : g_reg_chk
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result_out)));

    assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (result_out == $past(model_full[2*WIDTH-1 -: WIDTH])));

    assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && count_in == '0) |=> (result_out == $past(hi_in)));

    assert_idle_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_ready) |=> !out_valid);
  end
endmodule

bind funnel_shift_mt funnel_shift_mt_chk #(
  .WIDTH(WIDTH), .STEP(STEP), .OUT_MODE(OUT_MODE)
) u_chk (.*);

// File: tb/funnel_shift_mt_bench.sv
`timescale 1ns/1ps
module funnel_shift_mt_bench;
  localparam int W  = 32;
  localparam int CW = 5;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  hi_in = '0;
  logic [W-1:0]  lo_in = '0;
  logic [CW-1:0] count_in = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  result_out;

  bit   bp_rand = 1'b0;
  bit   rdy_forced = 1'b1;
  bit   done = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  item_t sb [$];

  always #2 clk = ~clk;

  funnel_shift_mt u_funnel_shift_mt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hi_in(hi_in), .lo_in(lo_in), .count_in(count_in),
    .out_valid(out_valid), .out_ready(out_ready), .result_out(result_out)
  );

  always @(negedge clk) begin
    out_ready <= bp_rand ? ($urandom_range(0, 3) != 0) : rdy_forced;
  end

  function automatic logic [W-1:0] window(logic [W-1:0] h, logic [W-1:0] l, logic [CW-1:0] c);
    logic [2*W-1:0] f;
    f = {h, l} << c;
    return f[2*W-1 -: W];
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] h, logic [W-1:0] l, logic [CW-1:0] c, string req);
    item_t it;
    @(negedge clk);
    hi_in = h; lo_in = l; count_in = c; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.exp = window(h, l, c);
    it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compares each result as it is taken by the consumer.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", result_out, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(result_out === it.exp, it.req, result_out, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] held;
    // Reset state: R8, R7
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", W'(out_valid), '0);
    check(in_ready == 1'b1, "R7", W'(in_ready), 32'h1);

    // Zero count and one-cycle latency: R2, R5, then idle drain R9
    send(32'hA5C3_0F17, 32'h1234_5678, 5'd0, "R2");
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R5", W'(out_valid), 32'h1);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", W'(out_valid), '0);

    // Back-pressure: R6, R7
    rdy_forced = 1'b0;
    @(negedge clk);
    send(32'hDEAD_BEEF, 32'h0BAD_F00D, 5'd7, "R1");
    @(negedge clk);
    hi_in = 32'hFFFF_0000; count_in = 5'd9;
    #1;
    held = result_out;
    check(in_ready == 1'b0, "R7", W'(in_ready), '0);
    check(out_valid == 1'b1, "R6", W'(out_valid), 32'h1);
    repeat (3) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b1 && result_out == held, "R6", result_out, held);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    rdy_forced = 1'b1;
    repeat (3) @(negedge clk);

    // Full count sweep under random back-pressure: R1, R2, R3, R4
    bp_rand = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < W; c++) begin
        logic [W-1:0] h;
        logic [W-1:0] l;
        string tag;
        case (p)
          0: begin h = 32'hFFFF_FFFF; l = 32'h0; end
          1: begin h = 32'h0; l = 32'hFFFF_FFFF; end
          2: begin h = 32'h8000_0001; l = 32'h8000_0001; end
          3: begin h = 32'hAAAA_AAAA; l = 32'h5555_5555; end
          default: begin h = $urandom; l = $urandom; end
        endcase
        if (c == 0) tag = "R2";
        else if (c == W - 1) tag = "R3";
        else if ((c % 4) == 0) tag = "R4";
        else tag = "R1";
        send(h, l, CW'(c), tag);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    bp_rand = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9", W'(out_valid), '0);
    done = 1'b1;
    finish_run();
  end
endmodule